// File: doc/BRIEF.md
# Inbound Message Segment Admission Controller

This block answers every received message segment with one of three verdicts: accept (DONE), reject (ERROR) or defer (RETRY). A segment arrives as a set of header fields: mailbox, letter, segment index, segment count minus one, and total message size. The block looks the mailbox up in a mailbox-to-queue map. It then weighs the state of the selected queue: whether it is initialized, whether it is torn down, how many free buffer descriptors it has, and how large its buffer is. It also consults its own record of which multi-segment message each queue is currently serving.

The block keeps two pieces of state. The first is a context per queue: an active bit plus the mailbox/letter key of the message that owns the queue. The second is a sticky reject bit per multi-segment mailbox/letter key. Once a segment of a message is rejected, the remaining segments of that message are rejected too. Each message that is accepted consumes exactly one buffer descriptor, and the block signals this with a pulse on its first segment.

The controller is a three-state machine that handles one segment at a time. In IDLE it raises `in_ready`, and the transition IDLE to LOOK captures the header when `seg_valid` is high. The transition LOOK to DECIDE registers the map lookup and the queue status. The transition DECIDE to IDLE registers the response, updates the contexts and updates the sticky bits. The response pulse therefore appears two clock edges after the edge that captured the segment.

Top module: `imsg_admit`

## Requirements
- R1: Each segment captured while `in_ready` is high produces exactly one single-cycle `rsp_valid` pulse, and responses come out in capture order. `rsp_code` is DONE=0, ERROR=1, RETRY=2.
- R2: A segment gets ERROR in any of these cases: its mailbox is unmapped; its mailbox maps to a queue index of NQ or more; or it belongs to a multi-segment message (count minus one not zero) whose mailbox is 4 or higher.
- R3: A segment whose mapped queue is not initialized (`q_ready` low) or is torn down (`q_torn` high) gets ERROR.
- R4: A first segment (index 0) whose queue has a free-descriptor count of zero gets ERROR.
- R5: A first segment whose message size is strictly greater than the queue's buffer size gets ERROR. A size equal to the buffer size is accepted.
- R6: After an ERROR to a non-last segment of a multi-segment message, every later segment of the same mailbox/letter gets ERROR, up to and including the last segment (index equal to count minus one). A new index-0 segment is evaluated afresh.
- R7: RETRY is returned in two cases. The first is the first segment of a multi-segment message whose queue is serving another message. The second is a non-first segment whose message does not own its queue.
- R8: A DONE to a first segment pulses `desc_take` together with `acc_valid` and `acc_queue`. A DONE to a later segment pulses `acc_valid` without `desc_take`.
- R9: A single-segment message is accepted even while its queue is serving a multi-segment message.
- R10: A queue's context is released when the last segment of its message is accepted, or when a segment of that message gets ERROR. After release, a new multi-segment message on that queue is accepted.
- R11: The checks are applied in this priority order: mapping, queue state, free descriptors, size, busy. For example, a busy queue with zero free descriptors gives ERROR, not RETRY.
- R12: After reset `rsp_valid`, `acc_valid` and `desc_take` are low, `in_ready` is high, no queue is busy and no sticky reject is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_valid | input | 1 | Segment header present (sampled in IDLE) |
| in_ready | output | 1 | Controller idle, able to take a segment |
| seg_mbox | input | MBOX_W | Mailbox number |
| seg_letter | input | LETTER_W | Letter number |
| seg_idx | input | SEG_W | Segment index, 0 for first |
| seg_total_m1 | input | SEG_W | Segment count minus one |
| seg_size | input | SIZE_W | Total message size |
| mb_map_valid | input | 2**MBOX_W | Per-mailbox mapping enable |
| mb_map_queue | input | 2**MBOX_W*QIDX_W | Per-mailbox queue index |
| q_ready | input | NQ | Queue initialized |
| q_torn | input | NQ | Queue torn down |
| q_free_cnt | input | NQ*FREE_W | Free descriptors per queue |
| q_buf_size | input | NQ*SIZE_W | Buffer size per queue |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | DONE=0, ERROR=1, RETRY=2 |
| acc_valid | output | 1 | Segment accepted |
| acc_queue | output | QIDX_W | Queue of accepted segment |
| desc_take | output | 1 | One descriptor consumed |

## Verification
On every cycle the assertions check several invariants. Every descriptor pulse coincides with a DONE acceptance. A RETRY never accepts or consumes. Responses are single-cycle pulses. The context store never opens a queue that is already busy and never closes a queue that is idle. The verdict itself can only be shown by scenarios: the priority between the rejection causes, the sticky rejection that runs across the segments of one message, the release of a context by completion or by abort, and the acceptance of a single-segment message while its queue is busy. The bench predicts each of these responses from the requirements.

// File: rtl/imsg_admit_pkg.sv
package imsg_admit_pkg;
    typedef enum logic [1:0] {
        RSP_DONE  = 2'd0,
        RSP_ERROR = 2'd1,
        RSP_RETRY = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_DECIDE = 2'd2
    } adm_state_e;
endpackage

// File: rtl/imsg_map_lookup.sv
module imsg_map_lookup #(
    parameter int MBOX_W     = 6,
    parameter int QIDX_W     = 3,
    parameter int NQ         = 6,
    parameter int MULTI_MBOX = 4
) (
    input  logic [MBOX_W-1:0]               mbox_i,
    input  logic                            multi_i,
    input  logic [(1<<MBOX_W)-1:0]          map_valid_i,
    input  logic [(1<<MBOX_W)*QIDX_W-1:0]   map_queue_i,
    output logic                            map_ok_o,
    output logic [QIDX_W-1:0]               qidx_o
);
    localparam int NMBOX = 1 << MBOX_W;
    localparam logic [MBOX_W-1:0] MULTI_LIM = MBOX_W'(MULTI_MBOX);
    localparam logic [QIDX_W:0]   NQ_LIM    = (QIDX_W+1)'(NQ);

    logic [QIDX_W-1:0] qtab [NMBOX];

    for (genvar m = 0; m < NMBOX; m++) begin : g_tab
        assign qtab[m] = map_queue_i[m*QIDX_W +: QIDX_W];
    end

    // R2: unmapped, nonexistent queue, or multi-segment on a high mailbox
    always_comb begin
        qidx_o   = qtab[mbox_i];
        map_ok_o = map_valid_i[mbox_i]
                && ({1'b0, qidx_o} < NQ_LIM)
                && !(multi_i && (mbox_i >= MULTI_LIM));
    end
endmodule

// File: rtl/imsg_verdict.sv
module imsg_verdict
    import imsg_admit_pkg::*;
(
    input  logic      first_i,
    input  logic      last_i,
    input  logic      multi_i,
    input  logic      sticky_hit_i,
    input  logic      map_ok_i,
    input  logic      q_ready_i,
    input  logic      q_torn_i,
    input  logic      has_free_i,
    input  logic      oversize_i,
    input  logic      q_active_i,
    input  logic      owner_i,
    output rsp_code_e code_o,
    output logic      take_o,
    output logic      open_o,
    output logic      close_o
);
    // R11: fixed priority of the rejection causes
    always_comb begin
        if (!first_i && sticky_hit_i)        code_o = RSP_ERROR;  // R6
        else if (!map_ok_i)                  code_o = RSP_ERROR;  // R2
        else if (!q_ready_i || q_torn_i)     code_o = RSP_ERROR;  // R3
        else if (!first_i)                   code_o = (q_active_i && owner_i) ? RSP_DONE : RSP_RETRY;
        else if (!has_free_i)                code_o = RSP_ERROR;  // R4
        else if (oversize_i)                 code_o = RSP_ERROR;  // R5
        else if (multi_i && q_active_i)      code_o = RSP_RETRY;  // R7
        else                                 code_o = RSP_DONE;   // R9 single passes busy

        take_o  = first_i && (code_o == RSP_DONE);
        open_o  = first_i && multi_i && (code_o == RSP_DONE);
        close_o = !first_i && map_ok_i && q_active_i && owner_i
               && (((code_o == RSP_DONE) && last_i) || (code_o == RSP_ERROR));
    end
endmodule

// File: rtl/imsg_ctx.sv
module imsg_ctx #(
    parameter int QIDX_W = 3,
    parameter int KEY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QIDX_W-1:0] qsel_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              open_i,
    input  logic              close_i,
    input  logic              sticky_set_i,
    input  logic              sticky_clr_i,
    output logic              active_o,
    output logic              owner_o,
    output logic              sticky_o
);
    localparam int NQP  = 1 << QIDX_W;
    localparam int NKEY = 1 << KEY_W;

    logic [NQP-1:0]   act;
    logic [KEY_W-1:0] own [NQP];
    logic [NKEY-1:0]  sticky;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act    <= '0;
            sticky <= '0;
            for (int i = 0; i < NQP; i++) own[i] <= '0;
        end else begin
            if (open_i) begin
                act[qsel_i] <= 1'b1;
                own[qsel_i] <= key_i;
            end else if (close_i) begin
                act[qsel_i] <= 1'b0;
            end
            if (sticky_set_i)      sticky[key_i] <= 1'b1;
            else if (sticky_clr_i) sticky[key_i] <= 1'b0;
        end
    end

    assign active_o = act[qsel_i];
    assign owner_o  = (own[qsel_i] == key_i);
    assign sticky_o = sticky[key_i];

    // R7: a busy queue is never claimed by a second message
    a_r7_no_double_open: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |-> !act[qsel_i]);
    // R10: only a busy context is ever released
    a_r10_close_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |-> act[qsel_i]);
endmodule

// File: rtl/imsg_admit.sv
module imsg_admit
    import imsg_admit_pkg::*;
#(
    parameter int MBOX_W     = 6,
    parameter int LETTER_W   = 2,
    parameter int SEG_W      = 4,
    parameter int SIZE_W     = 12,
    parameter int FREE_W     = 7,
    parameter int QIDX_W     = 3,
    parameter int NQ         = 6,
    parameter int MULTI_MBOX = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          seg_valid,
    output logic                          in_ready,
    input  logic [MBOX_W-1:0]             seg_mbox,
    input  logic [LETTER_W-1:0]           seg_letter,
    input  logic [SEG_W-1:0]              seg_idx,
    input  logic [SEG_W-1:0]              seg_total_m1,
    input  logic [SIZE_W-1:0]             seg_size,
    input  logic [(1<<MBOX_W)-1:0]        mb_map_valid,
    input  logic [(1<<MBOX_W)*QIDX_W-1:0] mb_map_queue,
    input  logic [NQ-1:0]                 q_ready,
    input  logic [NQ-1:0]                 q_torn,
    input  logic [NQ*FREE_W-1:0]          q_free_cnt,
    input  logic [NQ*SIZE_W-1:0]          q_buf_size,
    output logic                          rsp_valid,
    output logic [1:0]                    rsp_code,
    output logic                          acc_valid,
    output logic [QIDX_W-1:0]             acc_queue,
    output logic                          desc_take
);
    localparam int NQP    = 1 << QIDX_W;
    localparam int MMB_W  = $clog2(MULTI_MBOX);
    localparam int KEY_W  = MMB_W + LETTER_W;
    localparam logic [MBOX_W-1:0] MULTI_LIM = MBOX_W'(MULTI_MBOX);

    adm_state_e state_q, state_d;

    // captured header
    logic [MBOX_W-1:0]   h_mbox;
    logic [LETTER_W-1:0] h_letter;
    logic [SEG_W-1:0]    h_idx, h_tot;
    logic [SIZE_W-1:0]   h_size;

    // lookup snapshot
    logic              l_map_ok, l_ready, l_torn, l_free, l_over;
    logic [QIDX_W-1:0] l_q;

    // per-queue status padded to a power of two
    logic [NQP-1:0]    rdy_p, torn_p;
    logic [FREE_W-1:0] free_arr [NQP];
    logic [SIZE_W-1:0] size_arr [NQP];

    for (genvar q = 0; q < NQP; q++) begin : g_qstat
        if (q < NQ) begin : g_real
            assign rdy_p[q]    = q_ready[q];
            assign torn_p[q]   = q_torn[q];
            assign free_arr[q] = q_free_cnt[q*FREE_W +: FREE_W];
            assign size_arr[q] = q_buf_size[q*SIZE_W +: SIZE_W];
        end else begin : g_pad
            assign rdy_p[q]    = 1'b0;
            assign torn_p[q]   = 1'b0;
            assign free_arr[q] = '0;
            assign size_arr[q] = '0;
        end
    end

    logic              multi, first, last, sticky_ok;
    logic [KEY_W-1:0]  key;
    logic              map_ok;
    logic [QIDX_W-1:0] map_q;
    logic              c_active, c_owner, c_sticky;
    rsp_code_e         v_code;
    logic              v_take, v_open, v_close;
    logic              in_decide;

    assign multi     = (h_tot != '0);
    assign first     = (h_idx == '0);
    assign last      = (h_idx == h_tot);
    assign key       = {h_mbox[MMB_W-1:0], h_letter};
    assign sticky_ok = multi && (h_mbox < MULTI_LIM);
    assign in_decide = (state_q == ST_DECIDE);
    assign in_ready  = (state_q == ST_IDLE);

    imsg_map_lookup #(
        .MBOX_W(MBOX_W), .QIDX_W(QIDX_W), .NQ(NQ), .MULTI_MBOX(MULTI_MBOX)
    ) u_map (
        .mbox_i(h_mbox), .multi_i(multi),
        .map_valid_i(mb_map_valid), .map_queue_i(mb_map_queue),
        .map_ok_o(map_ok), .qidx_o(map_q)
    );

    imsg_ctx #(.QIDX_W(QIDX_W), .KEY_W(KEY_W)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .qsel_i(l_q), .key_i(key),
        .open_i(in_decide && v_open),
        .close_i(in_decide && v_close),
        .sticky_set_i(in_decide && sticky_ok && (v_code == RSP_ERROR) && !last),
        .sticky_clr_i(in_decide && sticky_ok && (first || last)),
        .active_o(c_active), .owner_o(c_owner), .sticky_o(c_sticky)
    );

    imsg_verdict u_verdict (
        .first_i(first), .last_i(last), .multi_i(multi),
        .sticky_hit_i(sticky_ok && c_sticky),
        .map_ok_i(l_map_ok), .q_ready_i(l_ready), .q_torn_i(l_torn),
        .has_free_i(l_free), .oversize_i(l_over),
        .q_active_i(c_active), .owner_i(c_owner),
        .code_o(v_code), .take_o(v_take), .open_o(v_open), .close_o(v_close)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: IDLE->LOOK on seg_valid, LOOK->DECIDE, DECIDE->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (seg_valid) state_d = ST_LOOK;
            ST_LOOK:   state_d = ST_DECIDE;
            ST_DECIDE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // header capture and lookup snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_mbox <= '0; h_letter <= '0; h_idx <= '0; h_tot <= '0; h_size <= '0;
            l_map_ok <= 1'b0; l_ready <= 1'b0; l_torn <= 1'b0;
            l_free <= 1'b0; l_over <= 1'b0; l_q <= '0;
        end else begin
            if (state_q == ST_IDLE && seg_valid) begin
                h_mbox <= seg_mbox; h_letter <= seg_letter;
                h_idx <= seg_idx; h_tot <= seg_total_m1; h_size <= seg_size;
            end
            if (state_q == ST_LOOK) begin
                l_map_ok <= map_ok;
                l_q      <= map_q;
                l_ready  <= rdy_p[map_q];
                l_torn   <= torn_p[map_q];
                l_free   <= (free_arr[map_q] != '0);
                l_over   <= (h_size > size_arr[map_q]);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_code <= 2'd0;
            acc_valid <= 1'b0; acc_queue <= '0; desc_take <= 1'b0;
        end else begin
            rsp_valid <= in_decide;
            rsp_code  <= in_decide ? v_code : 2'd0;
            acc_valid <= in_decide && (v_code == RSP_DONE);
            acc_queue <= l_q;
            desc_take <= in_decide && v_take;
        end
    end

    // R8: a descriptor is consumed only with a DONE acceptance
    a_r8_take_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        desc_take |-> (acc_valid && rsp_valid && rsp_code == 2'd0));
    // R1: responses are single-cycle pulses
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R7: a deferred segment neither accepts nor consumes
    a_r7_retry_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> (!acc_valid && !desc_take));
    // R1: no acceptance without a response
    a_r1_accept_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> rsp_valid);
endmodule

// File: tb/test_imsg_admit.sv
module test_imsg_admit;
    localparam int NQ = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seg_valid = 1'b0;
    logic in_ready;
    logic [5:0]  seg_mbox = '0;
    logic [1:0]  seg_letter = '0;
    logic [3:0]  seg_idx = '0, seg_total_m1 = '0;
    logic [11:0] seg_size = '0;
    logic [63:0]  map_v = '0;
    logic [191:0] map_q = '0;
    logic [NQ-1:0] q_ready = '0, q_torn = '0;
    logic [NQ*7-1:0]  q_free = '0;
    logic [NQ*12-1:0] q_size = '0;
    logic rsp_valid, acc_valid, desc_take;
    logic [1:0] rsp_code;
    logic [2:0] acc_queue;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [1:0] code;
        logic       take;
        logic [2:0] q;
    } exp_t;
    exp_t  sb_exp[$];
    string sb_tag[$];

    always #4 clk = ~clk;

    imsg_admit i_imsg_admit (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .in_ready(in_ready),
        .seg_mbox(seg_mbox), .seg_letter(seg_letter), .seg_idx(seg_idx),
        .seg_total_m1(seg_total_m1), .seg_size(seg_size),
        .mb_map_valid(map_v), .mb_map_queue(map_q),
        .q_ready(q_ready), .q_torn(q_torn), .q_free_cnt(q_free), .q_buf_size(q_size),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .acc_valid(acc_valid),
        .acc_queue(acc_queue), .desc_take(desc_take)
    );

    // monitor: pops and compares each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sb_exp.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected response actual code=%0d expected none", rsp_code);
            end else begin
                exp_t  e;
                string t;
                logic  ok;
                e = sb_exp.pop_front();
                t = sb_tag.pop_front();
                ok = (rsp_code == e.code) && (desc_take == e.take)
                  && (acc_valid == (e.code == 2'd0))
                  && (!acc_valid || acc_queue == e.q);
                if (!ok) begin
                    fails++;
                    $display("FAIL %s actual code=%0d take=%0d acc=%0d q=%0d expected code=%0d take=%0d q=%0d",
                             t, rsp_code, desc_take, acc_valid, acc_queue, e.code, e.take, e.q);
                end
            end
        end
    end

    task automatic send(input logic [5:0] mb, input logic [1:0] lt, input logic [3:0] idx,
                        input logic [3:0] tot, input logic [11:0] sz,
                        input logic [1:0] code, input logic take, input logic [2:0] q,
                        input string tag);
        exp_t e;
        e.code = code; e.take = take; e.q = q;
        sb_exp.push_back(e);
        sb_tag.push_back(tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        seg_mbox = mb; seg_letter = lt; seg_idx = idx; seg_total_m1 = tot; seg_size = sz;
        seg_valid = 1'b1;
        @(negedge clk);
        seg_valid = 1'b0;
        while (sb_exp.size() != 0) @(negedge clk);
    endtask

    task automatic map(input int mb, input logic [2:0] q);
        map_v[mb] = 1'b1;
        map_q[mb*3 +: 3] = q;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        map(0, 3'd0); map(1, 3'd1); map(2, 3'd2); map(3, 3'd7);
        map(5, 3'd3); map(7, 3'd4);
        q_ready = 6'b111011;
        q_torn  = 6'b010000;
        q_free  = {7'd1, 7'd3, 7'd2, 7'd3, 7'd0, 7'd4};
        q_size  = {12'd128, 12'd256, 12'd64, 12'd256, 12'd256, 12'd256};
        repeat (3) @(negedge clk);
        // R12: reset state
        checks++;
        if (rsp_valid || acc_valid || desc_take || !in_ready) begin
            fails++;
            $display("FAIL R12 reset actual rv=%0d av=%0d dt=%0d rdy=%0d expected 0 0 0 1",
                     rsp_valid, acc_valid, desc_take, in_ready);
        end
        rst_n = 1'b1;

        send(5, 0, 0, 0, 12'd32,  2'd0, 1, 3'd3, "R8 single accept takes descriptor");
        send(6, 0, 0, 0, 12'd32,  2'd1, 0, 3'd0, "R2 unmapped mailbox");
        send(3, 0, 0, 0, 12'd32,  2'd1, 0, 3'd0, "R2 nonexistent queue");
        send(2, 0, 0, 0, 12'd32,  2'd1, 0, 3'd0, "R3 uninitialized queue");
        send(7, 0, 0, 0, 12'd32,  2'd1, 0, 3'd0, "R3 torn-down queue");
        send(1, 0, 0, 0, 12'd32,  2'd1, 0, 3'd0, "R4 no free descriptor");
        send(5, 0, 0, 0, 12'd100, 2'd1, 0, 3'd0, "R5 oversize");
        send(5, 1, 0, 0, 12'd64,  2'd0, 1, 3'd3, "R5 equal size accepted");
        send(5, 0, 0, 1, 12'd32,  2'd1, 0, 3'd0, "R2 multi-segment on high mailbox");

        send(0, 0, 0, 2, 12'd200, 2'd0, 1, 3'd0, "R8 first of multi");
        send(0, 1, 0, 1, 12'd50,  2'd2, 0, 3'd0, "R7 busy queue first segment");
        send(0, 1, 1, 1, 12'd50,  2'd2, 0, 3'd0, "R7 non-owner continuation");
        send(0, 3, 0, 0, 12'd16,  2'd0, 1, 3'd0, "R9 single while busy");
        send(0, 0, 1, 2, 12'd200, 2'd0, 0, 3'd0, "R8 continuation no take");
        q_free[6:0] = 7'd0;
        send(0, 2, 0, 1, 12'd50,  2'd1, 0, 3'd0, "R11 no free beats busy");
        q_free[6:0] = 7'd4;
        send(0, 2, 0, 1, 12'd300, 2'd1, 0, 3'd0, "R11 oversize beats busy");
        send(0, 0, 2, 2, 12'd200, 2'd0, 0, 3'd0, "R10 last segment accepted");
        send(0, 1, 0, 1, 12'd50,  2'd0, 1, 3'd0, "R10 queue freed after last");
        send(0, 1, 1, 1, 12'd50,  2'd0, 0, 3'd0, "R8 last continuation");

        send(0, 2, 0, 2, 12'd300, 2'd1, 0, 3'd0, "R5 oversize multi first");
        send(0, 2, 1, 2, 12'd10,  2'd1, 0, 3'd0, "R6 sticky middle");
        send(0, 2, 2, 2, 12'd10,  2'd1, 0, 3'd0, "R6 sticky last");
        send(0, 2, 0, 1, 12'd100, 2'd0, 1, 3'd0, "R6 fresh message accepted");
        send(0, 2, 1, 1, 12'd100, 2'd0, 0, 3'd0, "R6 fresh continuation");

        send(0, 0, 0, 2, 12'd100, 2'd0, 1, 3'd0, "R10 abort setup");
        q_torn[0] = 1'b1;
        send(0, 0, 1, 2, 12'd100, 2'd1, 0, 3'd0, "R10 abort on torn queue");
        q_torn[0] = 1'b0;
        send(0, 0, 2, 2, 12'd100, 2'd1, 0, 3'd0, "R6 remainder after abort");
        send(0, 3, 0, 1, 12'd20,  2'd0, 1, 3'd0, "R10 queue released by error");
        send(0, 3, 1, 1, 12'd20,  2'd0, 0, 3'd0, "R10 released queue completes");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule